// File: doc/BRIEF.md
# Audio DMA Channel Register and Interrupt Block

This block is the host-visible register file of a three-channel audio bus-master engine. Channel 0 carries PCM capture, channel 1 PCM playback and channel 2 microphone capture. Each channel keeps its own registers: a buffer-list base address, a current index, a last valid index, a prefetch index, a remaining sample count, a status word and a control byte. A global control register, a global status register and a codec access semaphore sit next to the channel windows. The host reaches all of them through a simple register bus with byte, word and dword accesses. The block applies the masking rules for read-only, write-one-to-clear and reserved bits.

The descriptor sequencer sits outside this block. It loads the current index, prefetch index, remaining count and the two progress flags, and it pulses per-channel event inputs that set the sticky status bits. The block folds the status and enable bits into one level interrupt. The level is re-evaluated only when the set of sticky interrupt bits changes, so changing an enable bit alone has no effect on the line. A summary bit in global status mirrors each channel's level. The semaphore is set by the act of reading it, and any access to the codec mixer space clears it.

Top module: `adma_regs_top`

## Requirements
- R1: After reset every channel register reads 0 except status, which reads 0x0001 (halted). Global control and the semaphore read 0, a dword read of global status (0x30) returns 0x00000100, and irq_o, run_o and glob_ctl_o are 0.
- R2: bus_size_i encodes 0 = byte, 1 = word, 2 = dword. Channel c owns 0x10*c..0x10*c+0xF. Write data and read data are right-justified, and byte and word reads are zero-extended. The channel fields are: base at +0 (dword), current index at +4 (byte), last index at +5 (byte), status at +6 (byte returns bits 7:0, word returns all bits), count at +8 (word), prefetch index at +10 (byte) and control at +11 (byte). A dword read at +4 returns {status, last, current} in bits [31:16], [15:8] and [7:0]. A dword read at +8 returns {control, prefetch, count} in bits [31:24], [23:16] and [15:0].
- R3: A dword write to +0 stores the value with bits 1:0 forced to 0. A byte write to +5 stores the low 5 bits.
- R4: A byte write to control without bit 1 stores bits 4:0 and drives run_o. Bit 0 = 0 sets status bit 0 (halted), and bit 0 = 1 clears it.
- R5: A control write with bit 1 set does not store the written value. It zeroes the base, the current, last and prefetch indices and the count. It sets status to 0x01 and keeps only control bits 4:2.
- R6: Status bits 4:2 are cleared by writing 1 through a byte or word write to +6, and bits 1:0 ignore writes. Event input evt_i[3c+k] sets status bit 2+k of channel c, and it wins over a host clear in the same cycle.
- R7: A channel's interrupt level changes only in a cycle where status bits 4:2 change. It goes to 0 if all three bits become 0. It goes to 1 if bit 2 is set with control bit 2, or if bit 3 is set with control bit 4. Otherwise it keeps its value.
- R8: Global status bits 5, 6 and 7 read the levels of channels 0, 1 and 2, and irq_o is the OR of the levels.
- R9: A dword write to 0x2C stores bits 5:0 only when bits 2 and 1 of the written value are both 0. Otherwise the register keeps its value. The register drives glob_ctl_o.
- R10: In global status, bits 17:16 are read/write. Bits 15, 11, 10 and 0 are set by glob_set_i[3], [2], [1] and [0] and cleared by writing 1 (a set wins over a clear). All other bits ignore writes, and bit 8 always reads 1.
- R11: A byte read of 0x34 returns the semaphore in bit 0 and then sets it to 1. A mix_acc_i pulse clears it, and wins over a read in the same cycle.
- R12: Any other offset, or any access size not listed in R2, R9, R10 or R11, reads 0xFFFFFFFF. Such writes change nothing, and that includes writes to current index, prefetch index and count.
- R13: seq_upd_i[c] loads channel c's current index, prefetch index and count, and loads status bits 1:0 from seq_flg_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data, right-justified |
| bus_rdata_o | output | 32 | Read data, combinational from address and size |
| mix_acc_i | input | 1 | Pulse on any codec mixer access; clears the semaphore |
| evt_i | input | 9 | Per-channel status set pulses, 3 per channel |
| seq_upd_i | input | 3 | Per-channel sequencer load strobe |
| seq_cur_i | input | 15 | Current index, 5 bits per channel |
| seq_pref_i | input | 15 | Prefetch index, 5 bits per channel |
| seq_cnt_i | input | 48 | Remaining count, 16 bits per channel |
| seq_flg_i | input | 6 | Status bits 1:0, 2 bits per channel |
| glob_set_i | input | 4 | Set pulses for global status bits 15, 11, 10, 0 |
| run_o | output | 3 | Control bit 0 per channel |
| bd_base_o | output | 96 | Buffer list base per channel |
| last_idx_o | output | 15 | Last valid index per channel |
| glob_ctl_o | output | 6 | Stored global control |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the interrupt level rules. The level may only rise with a matching bit and enable, may only fall when all sticky bits are clear, and holds while those bits are unchanged. They also check that global control writes with a reset request leave the register unchanged, and how the semaphore responds to reads and mixer accesses. Only the bench scenarios can show the following: the address decode and the dword packings, the mask applied to each write, the register-reset write, a host clear losing to a same-cycle event, and an enable change that leaves the line untouched.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int ST_W  = 5;
  localparam int CTL_W = 5;
  localparam int GS_W  = 18;
  localparam int GC_W  = 6;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } acc_size_e;

  // channel window offsets
  localparam logic [3:0] OFF_BASE = 4'h0;
  localparam logic [3:0] OFF_CUR  = 4'h4;
  localparam logic [3:0] OFF_LAST = 4'h5;
  localparam logic [3:0] OFF_ST   = 4'h6;
  localparam logic [3:0] OFF_CNT  = 4'h8;
  localparam logic [3:0] OFF_PREF = 4'hA;
  localparam logic [3:0] OFF_CTL  = 4'hB;

  localparam logic [7:0] A_GCTL = 8'h2C;
  localparam logic [7:0] A_GSTA = 8'h30;
  localparam logic [7:0] A_SEM  = 8'h34;

  // control bits
  localparam int C_RUN  = 0;
  localparam int C_RST  = 1;
  localparam int C_LVIE = 2;
  localparam int C_IOCE = 4;
  // status bits
  localparam int S_HALT = 0;
  localparam int S_LVBC = 2;
  localparam int S_BCIS = 3;

  localparam logic [CTL_W-1:0] CTL_KEEP = 5'b11100;
  localparam logic [GS_W-1:0]  GS_RW    = 18'h30000;
  localparam logic [GS_W-1:0]  GS_W1C   = 18'h08C01;
endpackage

// File: rtl/adma_chan.sv
module adma_chan
  import adma_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_base_i,
  input  logic              wr_last_i,
  input  logic              wr_ctl_i,
  input  logic              wr_st_i,
  input  logic [31:0]       wdata_i,
  input  logic [2:0]        evt_i,
  input  logic              seq_upd_i,
  input  logic [IDX_W-1:0]  seq_cur_i,
  input  logic [IDX_W-1:0]  seq_pref_i,
  input  logic [CNT_W-1:0]  seq_cnt_i,
  input  logic [1:0]        seq_flg_i,
  output logic [31:0]       base_o,
  output logic [IDX_W-1:0]  cur_o,
  output logic [IDX_W-1:0]  last_o,
  output logic [IDX_W-1:0]  pref_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ST_W-1:0]   st_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              lvl_o
);
  logic [31:0]      base_q, base_d;
  logic [IDX_W-1:0] cur_q, cur_d, last_q, last_d, pref_q, pref_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ST_W-1:0]  st_q, st_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             lvl_q, lvl_d;

  always_comb begin
    base_d = base_q;
    cur_d  = cur_q;
    last_d = last_q;
    pref_d = pref_q;
    cnt_d  = cnt_q;
    st_d   = st_q;
    ctl_d  = ctl_q;
    if (seq_upd_i) begin
      cur_d      = seq_cur_i;
      pref_d     = seq_pref_i;
      cnt_d      = seq_cnt_i;
      st_d[1:0]  = seq_flg_i;
    end
    if (wr_base_i) base_d = {wdata_i[31:2], 2'b00};
    if (wr_last_i) last_d = wdata_i[IDX_W-1:0];
    if (wr_ctl_i) begin
      if (wdata_i[C_RST]) begin
        base_d = '0;
        cur_d  = '0;
        last_d = '0;
        pref_d = '0;
        cnt_d  = '0;
        st_d   = ST_W'(1);
        ctl_d  = ctl_q & CTL_KEEP;
      end else begin
        ctl_d          = wdata_i[CTL_W-1:0];
        st_d[S_HALT]   = ~wdata_i[C_RUN];
      end
    end
    if (wr_st_i) st_d[4:2] = st_d[4:2] & ~wdata_i[4:2];
    st_d[4:2] = st_d[4:2] | evt_i;  // event wins over host clear
  end

  // level re-evaluated only when sticky interrupt bits change
  always_comb begin
    lvl_d = lvl_q;
    if (st_d[4:2] != st_q[4:2]) begin
      if (st_d[4:2] == 3'b000) lvl_d = 1'b0;
      else if ((st_d[S_LVBC] && ctl_d[C_LVIE]) || (st_d[S_BCIS] && ctl_d[C_IOCE]))
        lvl_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
      last_q <= '0;
      pref_q <= '0;
      cnt_q  <= '0;
      st_q   <= ST_W'(1);
      ctl_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cur_q  <= cur_d;
      last_q <= last_d;
      pref_q <= pref_d;
      cnt_q  <= cnt_d;
      st_q   <= st_d;
      ctl_q  <= ctl_d;
      lvl_q  <= lvl_d;
    end
  end

  assign base_o = base_q;
  assign cur_o  = cur_q;
  assign last_o = last_q;
  assign pref_o = pref_q;
  assign cnt_o  = cnt_q;
  assign st_o   = st_q;
  assign ctl_o  = ctl_q;
  assign lvl_o  = lvl_q;

  assert_lvl_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lvl_q) |-> (st_q[4:2] == 3'b000));
  assert_lvl_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvl_q) |-> ((st_q[S_LVBC] && ctl_q[C_LVIE]) || (st_q[S_BCIS] && ctl_q[C_IOCE])));
  assert_lvl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(st_q[4:2]) |-> $stable(lvl_q));
  assert_evt_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != 3'b000) |=> ((st_q[4:2] & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/adma_glob.sv
module adma_glob
  import adma_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctl_i,
  input  logic             wr_sta_i,
  input  logic             rd_sem_i,
  input  logic [31:0]      wdata_i,
  input  logic [3:0]       glob_set_i,
  input  logic             mix_acc_i,
  input  logic [NCH-1:0]   lvl_i,
  output logic [GC_W-1:0]  ctl_o,
  output logic [31:0]      sta_rd_o,
  output logic             sem_o
);
  logic [GC_W-1:0] ctl_q;
  logic [GS_W-1:0] sta_q, sta_d, set_vec, sum_vec;
  logic            sem_q;

  assign set_vec = (GS_W'(glob_set_i[3]) << 15) | (GS_W'(glob_set_i[2]) << 11) |
                   (GS_W'(glob_set_i[1]) << 10) |  GS_W'(glob_set_i[0]);

  always_comb begin
    sta_d = sta_q;
    if (wr_sta_i) begin
      sta_d = (sta_d & ~GS_RW) | (wdata_i[GS_W-1:0] & GS_RW);
      sta_d = sta_d & ~(wdata_i[GS_W-1:0] & GS_W1C);
    end
    sta_d = sta_d | set_vec;
  end

  always_comb begin
    sum_vec = '0;
    for (int c = 0; c < NCH; c++) sum_vec[5+c] = lvl_i[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      sta_q <= '0;
      sem_q <= 1'b0;
    end else begin
      if (wr_ctl_i && !wdata_i[2] && !wdata_i[1]) ctl_q <= wdata_i[GC_W-1:0];
      sta_q <= sta_d;
      if (mix_acc_i)     sem_q <= 1'b0;
      else if (rd_sem_i) sem_q <= 1'b1;
    end
  end

  assign ctl_o    = ctl_q;
  assign sta_rd_o = 32'(sta_q | sum_vec | (GS_W'(1) << 8));
  assign sem_o    = sem_q;

  assert_gctl_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl_i && (wdata_i[2] || wdata_i[1])) |=> $stable(ctl_q));
  assert_sem_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sem_i && !mix_acc_i) |=> sem_q);
  assert_sem_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mix_acc_i |=> !sem_q);
endmodule

// File: rtl/adma_regs_top.sv
module adma_regs_top
  import adma_pkg::*;
#(
  parameter int NCH    = 3,   // at most 3: window 3 holds globals
  parameter int IDX_W  = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic [1:0]           bus_size_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic                 mix_acc_i,
  input  logic [NCH*3-1:0]     evt_i,
  input  logic [NCH-1:0]       seq_upd_i,
  input  logic [NCH*IDX_W-1:0] seq_cur_i,
  input  logic [NCH*IDX_W-1:0] seq_pref_i,
  input  logic [NCH*CNT_W-1:0] seq_cnt_i,
  input  logic [NCH*2-1:0]     seq_flg_i,
  input  logic [3:0]           glob_set_i,
  output logic [NCH-1:0]       run_o,
  output logic [NCH*32-1:0]    bd_base_o,
  output logic [NCH*IDX_W-1:0] last_idx_o,
  output logic [GC_W-1:0]      glob_ctl_o,
  output logic                 irq_o
);
  logic [3:0] off;
  logic [1:0] sel;
  logic       win_hit, is_b, is_w, is_d, wr, rd;

  assign off     = bus_addr_i[3:0];
  assign sel     = bus_addr_i[5:4];
  assign win_hit = (bus_addr_i[ADDR_W-1:4] < (ADDR_W-4)'(NCH));
  assign is_b    = (bus_size_i == SZ_BYTE);
  assign is_w    = (bus_size_i == SZ_WORD);
  assign is_d    = (bus_size_i == SZ_DWORD);
  assign wr      = bus_req_i && bus_we_i;
  assign rd      = bus_req_i && !bus_we_i;

  logic [31:0]      base_a [NCH];
  logic [IDX_W-1:0] cur_a  [NCH];
  logic [IDX_W-1:0] last_a [NCH];
  logic [IDX_W-1:0] pref_a [NCH];
  logic [CNT_W-1:0] cnt_a  [NCH];
  logic [ST_W-1:0]  st_a   [NCH];
  logic [CTL_W-1:0] ctl_a  [NCH];
  logic [NCH-1:0]   lvl;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = wr && win_hit && (sel == 2'(c));
    adma_chan #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_base_i  (hit && is_d && off == OFF_BASE),
      .wr_last_i  (hit && is_b && off == OFF_LAST),
      .wr_ctl_i   (hit && is_b && off == OFF_CTL),
      .wr_st_i    (hit && (is_b || is_w) && off == OFF_ST),
      .wdata_i    (bus_wdata_i),
      .evt_i      (evt_i[c*3 +: 3]),
      .seq_upd_i  (seq_upd_i[c]),
      .seq_cur_i  (seq_cur_i[c*IDX_W +: IDX_W]),
      .seq_pref_i (seq_pref_i[c*IDX_W +: IDX_W]),
      .seq_cnt_i  (seq_cnt_i[c*CNT_W +: CNT_W]),
      .seq_flg_i  (seq_flg_i[c*2 +: 2]),
      .base_o     (base_a[c]),
      .cur_o      (cur_a[c]),
      .last_o     (last_a[c]),
      .pref_o     (pref_a[c]),
      .cnt_o      (cnt_a[c]),
      .st_o       (st_a[c]),
      .ctl_o      (ctl_a[c]),
      .lvl_o      (lvl[c])
    );
    assign run_o[c]                      = ctl_a[c][C_RUN];
    assign bd_base_o[c*32 +: 32]         = base_a[c];
    assign last_idx_o[c*IDX_W +: IDX_W]  = last_a[c];
  end

  logic [31:0] gsta_rd;
  logic        sem;

  adma_glob #(.NCH(NCH)) u_glob (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctl_i   (wr && is_d && bus_addr_i == ADDR_W'(A_GCTL)),
    .wr_sta_i   (wr && is_d && bus_addr_i == ADDR_W'(A_GSTA)),
    .rd_sem_i   (rd && is_b && bus_addr_i == ADDR_W'(A_SEM)),
    .wdata_i    (bus_wdata_i),
    .glob_set_i (glob_set_i),
    .mix_acc_i  (mix_acc_i),
    .lvl_i      (lvl),
    .ctl_o      (glob_ctl_o),
    .sta_rd_o   (gsta_rd),
    .sem_o      (sem)
  );

  assign irq_o = |lvl;

  always_comb begin
    bus_rdata_o = '1;
    if (win_hit) begin
      if (is_b) begin
        case (off)
          OFF_CUR:  bus_rdata_o = 32'(cur_a[sel]);
          OFF_LAST: bus_rdata_o = 32'(last_a[sel]);
          OFF_ST:   bus_rdata_o = 32'(st_a[sel]);
          OFF_PREF: bus_rdata_o = 32'(pref_a[sel]);
          OFF_CTL:  bus_rdata_o = 32'(ctl_a[sel]);
          default:  bus_rdata_o = '1;
        endcase
      end else if (is_w) begin
        case (off)
          OFF_ST:  bus_rdata_o = 32'(st_a[sel]);
          OFF_CNT: bus_rdata_o = 32'(cnt_a[sel]);
          default: bus_rdata_o = '1;
        endcase
      end else if (is_d) begin
        case (off)
          OFF_BASE: bus_rdata_o = base_a[sel];
          OFF_CUR:  bus_rdata_o = {11'b0, st_a[sel], 8'(last_a[sel]), 8'(cur_a[sel])};
          OFF_CNT:  bus_rdata_o = {3'b0, ctl_a[sel], 8'(pref_a[sel]), 16'(cnt_a[sel])};
          default:  bus_rdata_o = '1;
        endcase
      end
    end
    if (is_d && bus_addr_i == ADDR_W'(A_GCTL)) bus_rdata_o = 32'(glob_ctl_o);
    if (is_d && bus_addr_i == ADDR_W'(A_GSTA)) bus_rdata_o = gsta_rd;
    if (is_b && bus_addr_i == ADDR_W'(A_SEM))  bus_rdata_o = 32'(sem);
  end

  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gsta_rd[7:5] != 3'b000));
endmodule

// File: tb/adma_regs_top_tb_top.sv
module adma_regs_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  sz = 2'd0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = 32'h0, rdata;
  logic        mix = 1'b0;
  logic [8:0]  evt = '0;
  logic [2:0]  supd = '0;
  logic [14:0] scur = '0, spref = '0;
  logic [47:0] scnt = '0;
  logic [5:0]  sflg = '0;
  logic [3:0]  gset = '0;
  logic [2:0]  run;
  logic [95:0] bdb;
  logic [14:0] lidx;
  logic [5:0]  gctl;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adma_regs_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_size_i(sz),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mix_acc_i(mix),
    .evt_i(evt), .seq_upd_i(supd), .seq_cur_i(scur), .seq_pref_i(spref),
    .seq_cnt_i(scnt), .seq_flg_i(sflg), .glob_set_i(gset), .run_o(run),
    .bd_base_o(bdb), .last_idx_o(lidx), .glob_ctl_o(gctl), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [1:0] s, input logic [7:0] a,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req = 1'b1; we = w; sz = s; addr = a; wdata = d;
    #1 r = rdata;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic pulse_evt(input int idx);
    @(negedge clk);
    evt[idx] = 1'b1;
    @(posedge clk);
    #1 evt = '0;
  endtask

  // {we, size, addr, wdata, expected read, requirement number}
  localparam int NV = 28;
  localparam logic [82:0] VEC [NV] = '{
    {1'b0, 2'd2, 8'h04, 32'h0,        32'h00010000, 8'd1},  // R1
    {1'b0, 2'd1, 8'h06, 32'h0,        32'h00000001, 8'd1},  // R1
    {1'b0, 2'd2, 8'h30, 32'h0,        32'h00000100, 8'd1},  // R1
    {1'b1, 2'd2, 8'h00, 32'h12345677, 32'h0,        8'd3},  // R3
    {1'b0, 2'd2, 8'h00, 32'h0,        32'h12345674, 8'd3},  // R3
    {1'b1, 2'd0, 8'h15, 32'h000000FF, 32'h0,        8'd3},  // R3
    {1'b0, 2'd2, 8'h14, 32'h0,        32'h00011F00, 8'd2},  // R2
    {1'b0, 2'd0, 8'h15, 32'h0,        32'h0000001F, 8'd3},  // R3
    {1'b1, 2'd0, 8'h2B, 32'h000000FD, 32'h0,        8'd4},  // R4
    {1'b0, 2'd2, 8'h28, 32'h0,        32'h1D000000, 8'd2},  // R2
    {1'b0, 2'd0, 8'h26, 32'h0,        32'h00000000, 8'd4},  // R4
    {1'b0, 2'd0, 8'h2B, 32'h0,        32'h0000001D, 8'd4},  // R4
    {1'b1, 2'd2, 8'h2C, 32'hFFFFFFF9, 32'h0,        8'd9},  // R9
    {1'b0, 2'd2, 8'h2C, 32'h0,        32'h00000039, 8'd9},  // R9
    {1'b1, 2'd2, 8'h2C, 32'h00000004, 32'h0,        8'd9},  // R9
    {1'b0, 2'd2, 8'h2C, 32'h0,        32'h00000039, 8'd9},  // R9
    {1'b1, 2'd2, 8'h30, 32'hFFFFFFFF, 32'h0,        8'd10}, // R10
    {1'b0, 2'd2, 8'h30, 32'h0,        32'h00030100, 8'd10}, // R10
    {1'b0, 2'd0, 8'h34, 32'h0,        32'h00000000, 8'd11}, // R11
    {1'b0, 2'd0, 8'h34, 32'h0,        32'h00000001, 8'd11}, // R11
    {1'b0, 2'd2, 8'h44, 32'h0,        32'hFFFFFFFF, 8'd12}, // R12
    {1'b0, 2'd1, 8'h04, 32'h0,        32'hFFFFFFFF, 8'd12}, // R12
    {1'b0, 2'd0, 8'h3C, 32'h0,        32'hFFFFFFFF, 8'd12}, // R12
    {1'b1, 2'd0, 8'h24, 32'h00000007, 32'h0,        8'd12}, // R12
    {1'b0, 2'd0, 8'h24, 32'h0,        32'h00000000, 8'd12}, // R12
    {1'b1, 2'd0, 8'h2B, 32'h00000000, 32'h0,        8'd4},  // R4
    {1'b0, 2'd1, 8'h26, 32'h0,        32'h00000001, 8'd4},  // R4
    {1'b0, 2'd1, 8'h08, 32'h0,        32'h00000000, 8'd2}   // R2
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq_o", 32'(irq), 32'h0);
    chk("R1 run_o", 32'(run), 32'h0);
    chk("R1 glob_ctl_o", 32'(gctl), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][82], VEC[i][81:80], VEC[i][79:72], VEC[i][71:40], r);
      if (!VEC[i][82]) chk($sformatf("R%0d vector %0d", VEC[i][7:0], i), r, VEC[i][39:8]);
    end
    chk("R9 glob_ctl_o", 32'(gctl), 32'h39);

    // R7/R8: enable change without status change leaves the line alone
    bus(1, 0, 8'h1B, 32'h04, r);
    pulse_evt(4);                       // ch1 bit3, IOC enable off
    bus(0, 0, 8'h16, 0, r);
    chk("R6 ch1 status after event", r, 32'h09);
    chk("R7 no assert w/o enable", 32'(irq), 32'h0);
    bus(1, 0, 8'h1B, 32'h14, r);
    @(negedge clk);
    chk("R7 enable alone no assert", 32'(irq), 32'h0);
    pulse_evt(3);                       // ch1 bit2, LV enable on
    @(negedge clk);
    chk("R7 assert on LV", 32'(irq), 32'h1);
    bus(0, 2, 8'h30, 0, r);
    chk("R8 summary bit6", r, 32'h00030140);
    bus(1, 0, 8'h16, 32'h08, r);
    @(negedge clk);
    chk("R7 stays with LV set", 32'(irq), 32'h1);
    bus(1, 0, 8'h16, 32'h04, r);
    @(negedge clk);
    chk("R7 deassert when clear", 32'(irq), 32'h0);
    bus(0, 2, 8'h30, 0, r);
    chk("R8 summary cleared", r, 32'h00030100);

    // R6: event beats same-cycle clear
    pulse_evt(0);
    @(negedge clk);
    req = 1; we = 1; sz = 2'd0; addr = 8'h06; wdata = 32'h1C; evt[0] = 1'b1;
    @(posedge clk);
    #1 req = 0; we = 0; evt = '0;
    bus(0, 0, 8'h06, 0, r);
    chk("R6 event wins", r, 32'h05);

    // R13 / R5
    bus(1, 2, 8'h20, 32'hABCD0000, r);
    bus(1, 0, 8'h25, 32'h05, r);
    bus(1, 0, 8'h2B, 32'h15, r);
    @(negedge clk);
    chk("R4 run_o ch2", 32'(run[2]), 32'h1);
    supd[2] = 1; scur[14:10] = 5'd3; spref[14:10] = 5'd4; scnt[47:32] = 16'h1234; sflg[5:4] = 2'b10;
    @(posedge clk);
    #1 supd = '0;
    bus(0, 2, 8'h24, 0, r);
    chk("R13 cur/last/status", r, 32'h00020503);
    bus(0, 2, 8'h28, 0, r);
    chk("R13 cnt/pref/ctl", r, 32'h15041234);
    pulse_evt(7);
    @(negedge clk);
    chk("R7 assert on IOC ch2", 32'(irq), 32'h1);
    bus(1, 0, 8'h2B, 32'hFF, r);
    @(negedge clk);
    chk("R5 irq drops on reset write", 32'(irq), 32'h0);
    bus(0, 2, 8'h24, 0, r);
    chk("R5 idx/status", r, 32'h00010000);
    bus(0, 2, 8'h28, 0, r);
    chk("R5 ctl keeps enables", r, 32'h14000000);
    bus(0, 2, 8'h20, 0, r);
    chk("R5 base cleared", r, 32'h0);

    // R10: set inputs and write-one-to-clear
    @(negedge clk);
    gset = 4'hF;
    @(posedge clk);
    #1 gset = '0;
    bus(0, 2, 8'h30, 0, r);
    chk("R10 set bits", r, 32'h00038D01);
    bus(1, 2, 8'h30, 32'h00030401, r);
    bus(0, 2, 8'h30, 0, r);
    chk("R10 w1c", r, 32'h00038900);

    // R11: mixer access clears semaphore
    @(negedge clk);
    mix = 1;
    @(posedge clk);
    #1 mix = 0;
    bus(0, 0, 8'h34, 0, r);
    chk("R11 cleared by mixer", r, 32'h0);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R1 glob_ctl_o after reset", 32'(gctl), 32'h0);
    bus(0, 2, 8'h30, 0, r);
    chk("R1 gsta after reset", r, 32'h00000100);
    rst_n = 1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule